// File: doc/BRIEF.md
# Mixed Page Size Translation Cache

This block is a small, fully associative cache of address translations that sits between a processor's address path and a page-table walker. Each slot holds one mapping from a 32-bit virtual address to a physical address. Each slot also records its own page size: 4 KB, 64 KB, 1 MB or 16 MB. A lookup is purely combinational. The requester drives a virtual address and sees a hit flag and the translated physical address within the same cycle.

When a lookup misses, the walker fetches the translation from memory. It then hands the result to the refill port, together with the page size code, and the block installs it in a slot. Refill picks the lowest-numbered empty slot if there is one. When every slot is occupied, it uses a rotating victim pointer instead. A single invalidate-all input empties the whole cache in one clock. Software uses it after changing translation tables in memory.

The compare for a slot uses only the virtual address bits above that slot's page offset. The physical address is built from the slot's frame bits above the offset and the lookup address bits below it.

Top module: `mpt_tlb`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every slot is empty and every lookup misses.
- R2: A slot with size code 0 (4 KB) hits when lk_va[31:12] equals the stored virtual bits [31:12]. On a hit, lk_pa is the stored frame above bit 12 joined with lk_va[11:0].
- R3: A slot with size code 1 (64 KB) compares only bits [31:16]. The stored virtual bits [15:12] are ignored. On a hit, lk_pa[15:0] comes from lk_va and the bits above come from the stored frame, with stored frame bits [15:12] ignored.
- R4: A slot with size code 2 (1 MB) compares only bits [31:20]. On a hit, lk_pa[19:0] comes from lk_va.
- R5: A slot with size code 3 (16 MB) compares only bits [31:24]. On a hit, lk_pa[23:0] comes from lk_va.
- R6: lk_hit and lk_pa respond to lk_va in the same cycle, with no clock in between. A refill presented before a rising edge is visible to lookups only after that edge. Slot contents change only on a refill, an invalidate-all or a reset.
- R7: A refill goes into the lowest-numbered empty slot whenever an empty slot exists. The victim pointer is then neither used nor moved.
- R8: When all slots are full, a refill overwrites the slot named by the victim pointer, and the pointer then advances by one, wrapping from the last slot to slot 0. Exactly one slot is written per accepted refill. The pointer is 0 after reset, and invalidate-all leaves it unchanged.
- R9: An invalidate-all asserted before a rising edge empties every slot at that edge. A lookup made while invalidate-all is high reports a miss.
- R10: A refill asserted in the same cycle as invalidate-all is discarded.
- R11: If more than one slot matches a lookup, the lowest-numbered matching slot supplies the result, whatever the page sizes or the order of refill.
- R12: On a miss, lk_pa is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_pa | output | PA_W | Translated physical address, zero on a miss |
| fill_en | input | 1 | Install the translation on the fill inputs at this edge |
| fill_va | input | 32 | Virtual address of the new translation |
| fill_pa | input | PA_W | Physical address of the new translation |
| fill_size | input | 2 | Page size code: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB |
| inv_all | input | 1 | Empty every slot at this edge, and force a miss now |

## Verification
The checker watches the occupancy vector and the write strobe on every cycle. It checks that:
- an invalidate (with or without a refill beside it) leaves the cache empty;
- an accepted refill into a non-full cache adds exactly one entry;
- idle cycles leave occupancy untouched;
- at most one slot is written per cycle, and exactly one per accepted refill;
- a hit passes the 4 KB offset through, and a miss returns zero.

Only the bench scenarios can show the rest: the per-size masking of both the compare and the physical address; which slot a refill lands in; the wrap of the victim pointer; and priority among overlapping entries. The bench exposes these through lookups that reveal which translation survived.

// File: rtl/mpt_pkg.sv
// Package mpt_pkg
// Shared page-size type and mask helper for the mixed page size
// translation cache. Assumes 32-bit virtual addresses and a smallest page
// of 4 KB, so the virtual page number is always VA[31:12].
package mpt_pkg;

    localparam int VA_W    = 32;
    localparam int MIN_OFF = 12;
    localparam int VPN_W   = VA_W - MIN_OFF;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_size_e;

    // Bits of VA[31:12] that take part in the compare for a page size
    function automatic logic [VPN_W-1:0] vpn_mask(input pg_size_e sz);
        logic [VPN_W-1:0] m;
        case (sz)
            PG_4K:   m = {VPN_W{1'b1}};
            PG_64K:  m = {VPN_W{1'b1}} << 4;
            PG_1M:   m = {VPN_W{1'b1}} << 8;
            default: m = {VPN_W{1'b1}} << 12;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mpt_entry.sv
// Module mpt_entry
// One slot of the cache: a valid flag, the virtual page bits, the physical
// frame bits and the page size. It reports a match on the masked virtual
// page bits. Assumes clear has priority over write. Only the valid flag is
// reset; the data fields are meaningful only while it is set.
module mpt_entry
    import mpt_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  clr,
    input  logic [VPN_W-1:0]      wr_vpn,
    input  logic [PA_W-MIN_OFF-1:0] wr_frame,
    input  pg_size_e              wr_size,
    input  logic [VPN_W-1:0]      lk_vpn,
    output logic                  valid,
    output logic                  match,
    output logic [PA_W-MIN_OFF-1:0] frame,
    output logic [VPN_W-1:0]      mask
);

    localparam int FRM_W = PA_W - MIN_OFF;

    logic [VPN_W-1:0] tag_q;
    logic [FRM_W-1:0] frame_q;
    pg_size_e         size_q;

    // Valid flag: reset and invalidate clear it, a refill sets it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (wr_en) begin
            valid <= 1'b1;
        end
    end

    // Payload capture on refill
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_q   <= wr_vpn;
            frame_q <= wr_frame;
            size_q  <= wr_size;
        end
    end

    // Size-masked compare against the lookup page number
    always_comb begin
        mask  = vpn_mask(size_q);
        match = valid && (((tag_q ^ lk_vpn) & mask) == '0);
        frame = frame_q;
    end

endmodule

// File: rtl/mpt_repl.sv
// Module mpt_repl
// Chooses the slot that an accepted refill writes. The choice is the
// lowest-numbered empty slot, or the rotating victim pointer when every
// slot is full. Assumes NUM_ENTRIES >= 2. The pointer moves only when it
// is used.
module mpt_repl #(
    parameter int NUM_ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] valid_vec,
    input  logic                   fill_go,
    output logic [NUM_ENTRIES-1:0] wr_sel
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] tgt_idx;
    logic             found;
    logic             all_full;

    // Lowest-numbered empty slot
    always_comb begin
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!valid_vec[i] && !found) begin
                found    = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Target selection and one-hot write strobe
    always_comb begin
        all_full = &valid_vec;
        tgt_idx  = all_full ? ptr_q : free_idx;
        wr_sel   = fill_go ? (NUM_ENTRIES'(1) << tgt_idx) : '0;
    end

    // Victim pointer advances only on refills into a full cache
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_go && all_full) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

endmodule

// File: rtl/mpt_sel.sv
// Module mpt_sel
// Picks the lowest-numbered matching slot and forms the physical address.
// The frame bits come from the slot above its page offset, and the lookup
// address bits fill in below it. A kill input forces a miss. Assumes
// PA_W >= 32, so that every page offset lies inside the frame field.
module mpt_sel
    import mpt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int PA_W        = 32
) (
    input  logic [NUM_ENTRIES-1:0]  match_vec,
    input  logic [PA_W-MIN_OFF-1:0] frames [NUM_ENTRIES],
    input  logic [VPN_W-1:0]        masks  [NUM_ENTRIES],
    input  logic [VA_W-1:0]         lk_va,
    input  logic                    kill,
    output logic                    hit,
    output logic [PA_W-1:0]         pa
);

    localparam int FRM_W = PA_W - MIN_OFF;

    logic             raw_hit;
    logic [FRM_W-1:0] sel_frame;
    logic [VPN_W-1:0] sel_mask;
    logic [FRM_W-1:0] keep;
    logic [FRM_W-1:0] va_part;

    // Priority pick: the scan runs downward so the lowest index wins
    always_comb begin
        raw_hit   = 1'b0;
        sel_frame = '0;
        sel_mask  = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                raw_hit   = 1'b1;
                sel_frame = frames[i];
                sel_mask  = masks[i];
            end
        end
    end

    // Merge frame and offset bits; force zero output on a miss or kill
    always_comb begin
        keep    = ~FRM_W'(~sel_mask);
        va_part = FRM_W'(lk_va[VA_W-1:MIN_OFF] & ~sel_mask);
        hit     = raw_hit && !kill;
        pa      = hit ? {(sel_frame & keep) | va_part, lk_va[MIN_OFF-1:0]} : '0;
    end

endmodule

// File: rtl/mpt_tlb.sv
// Module mpt_tlb
// Fully associative translation cache with a per-slot page size. Lookup
// is combinational. Refill and invalidate-all act at the rising edge, and
// invalidate wins over a refill in the same cycle. Assumes the refill
// source never installs two slots that cover one address; if it does,
// the lowest-numbered slot is used.
module mpt_tlb
    import mpt_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int PA_W        = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     lk_va,
    output logic            lk_hit,
    output logic [PA_W-1:0] lk_pa,
    input  logic            fill_en,
    input  logic [31:0]     fill_va,
    input  logic [PA_W-1:0] fill_pa,
    input  logic [1:0]      fill_size,
    input  logic            inv_all
);

    localparam int FRM_W = PA_W - MIN_OFF;

    logic                   fill_go;
    logic [NUM_ENTRIES-1:0] wr_sel;
    logic [NUM_ENTRIES-1:0] ent_valid;
    logic [NUM_ENTRIES-1:0] ent_match;
    logic [FRM_W-1:0]       ent_frame [NUM_ENTRIES];
    logic [VPN_W-1:0]       ent_mask  [NUM_ENTRIES];
    logic                   sig_unused;

    // Refill is accepted only when no invalidate is pending
    always_comb begin
        fill_go    = fill_en && !inv_all;
        sig_unused = ^{fill_va[MIN_OFF-1:0], fill_pa[MIN_OFF-1:0]};
    end

    mpt_repl #(
        .NUM_ENTRIES(NUM_ENTRIES)
    ) u_repl (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_vec(ent_valid),
        .fill_go  (fill_go),
        .wr_sel   (wr_sel)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        mpt_entry #(
            .PA_W(PA_W)
        ) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[g]),
            .clr     (inv_all),
            .wr_vpn  (fill_va[VA_W-1:MIN_OFF]),
            .wr_frame(fill_pa[PA_W-1:MIN_OFF]),
            .wr_size (pg_size_e'(fill_size)),
            .lk_vpn  (lk_va[VA_W-1:MIN_OFF]),
            .valid   (ent_valid[g]),
            .match   (ent_match[g]),
            .frame   (ent_frame[g]),
            .mask    (ent_mask[g])
        );
    end

    mpt_sel #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .PA_W       (PA_W)
    ) u_sel (
        .match_vec(ent_match),
        .frames   (ent_frame),
        .masks    (ent_mask),
        .lk_va    (lk_va),
        .kill     (inv_all),
        .hit      (lk_hit),
        .pa       (lk_pa)
    );

endmodule

// File: rtl/mpt_tlb_chk.sv
// Module mpt_tlb_chk
// Cycle-by-cycle properties of the translation cache, attached to every
// mpt_tlb instance by the bind below. Observes the ports, the occupancy
// vector and the write strobe.
module mpt_tlb_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int PA_W        = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   inv_all,
    input logic                   fill_en,
    input logic                   lk_hit,
    input logic [31:0]            lk_va,
    input logic [PA_W-1:0]        lk_pa,
    input logic [NUM_ENTRIES-1:0] valid_vec,
    input logic [NUM_ENTRIES-1:0] wr_sel
);

    p_inv_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    p_inv_forces_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |-> !lk_hit);

    p_inv_drops_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && fill_en) |=> (valid_vec == '0));

    p_fill_adds_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_all && !(&valid_vec))
            |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en && !inv_all) |=> $stable(valid_vec));

    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    p_fill_writes_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !inv_all) |-> ($countones(wr_sel) == 1));

    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_pa[11:0] == lk_va[11:0]));

    p_miss_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0));

endmodule

bind mpt_tlb mpt_tlb_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .PA_W       (PA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_all  (inv_all),
    .fill_en  (fill_en),
    .lk_hit   (lk_hit),
    .lk_va    (lk_va),
    .lk_pa    (lk_pa),
    .valid_vec(ent_valid),
    .wr_sel   (wr_sel)
);

// File: tb/mpt_tlb_bench.sv
// Bench for mpt_tlb: a vector table for per-size matching, then directed
// tests for timing, invalidate, placement, victim wrap, priority and reset.
module mpt_tlb_bench;

    localparam int HALF = 4;  // 8 ns period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;
    logic        fill_en = 1'b0;
    logic [31:0] fill_va = '0;
    logic [31:0] fill_pa = '0;
    logic [1:0]  fill_size = '0;
    logic        inv_all = 1'b0;

    int checks = 0;
    int errors = 0;

    always #HALF clk = ~clk;

    mpt_tlb #(.NUM_ENTRIES(8), .PA_W(32)) u_mpt_tlb (
        .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .fill_en(fill_en), .fill_va(fill_va), .fill_pa(fill_pa),
        .fill_size(fill_size), .inv_all(inv_all)
    );

    typedef struct packed {
        logic        is_fill;
        logic [31:0] va;
        logic [31:0] pa;
        logic [1:0]  sz;
        logic        exp_hit;
        logic [31:0] exp_pa;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{1'b1, 32'h1234_5000, 32'hABCD_E000, 2'd0, 1'b0, 32'h0, 4'd2},        // R2 fill 4 KB
        '{1'b1, 32'h0056_3000, 32'h7700_F000, 2'd1, 1'b0, 32'h0, 4'd3},        // R3 fill 64 KB
        '{1'b1, 32'h3457_8000, 32'h9910_0000, 2'd2, 1'b0, 32'h0, 4'd4},        // R4 fill 1 MB
        '{1'b1, 32'hC300_0000, 32'h0512_3000, 2'd3, 1'b0, 32'h0, 4'd5},        // R5 fill 16 MB
        '{1'b0, 32'h1234_5ABC, 32'h0, 2'd0, 1'b1, 32'hABCD_EABC, 4'd2},        // R2 hit
        '{1'b0, 32'h1234_6ABC, 32'h0, 2'd0, 1'b0, 32'h0, 4'd2},                // R2 next page
        '{1'b0, 32'h0056_FFF0, 32'h0, 2'd0, 1'b1, 32'h7700_FFF0, 4'd3},        // R3 hit
        '{1'b0, 32'h0057_0000, 32'h0, 2'd0, 1'b0, 32'h0, 4'd3},                // R3 next page
        '{1'b0, 32'h345F_1234, 32'h0, 2'd0, 1'b1, 32'h991F_1234, 4'd4},        // R4 hit
        '{1'b0, 32'h3460_0000, 32'h0, 2'd0, 1'b0, 32'h0, 4'd4},                // R4 next page
        '{1'b0, 32'hC3AB_CDEF, 32'h0, 2'd0, 1'b1, 32'h05AB_CDEF, 4'd5},        // R5 hit
        '{1'b0, 32'hC400_0000, 32'h0, 2'd0, 1'b0, 32'h0, 4'd5}                 // R5 next page
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Lookup at the current time, sampled 1 ns later, between edges
    task automatic look(input string req, input logic [31:0] va,
                        input logic hit, input logic [31:0] pa);
        lk_va = va;
        #1;
        chk(req, {31'b0, lk_hit}, {31'b0, hit});
        chk(req, lk_pa, pa);
    endtask

    // Present one refill across one rising edge
    task automatic do_fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz);
        fill_en = 1'b1;
        fill_va = va;
        fill_pa = pa;
        fill_size = sz;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inv();
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12: empty after reset, zero address on miss
        look("R1", 32'h1234_5000, 1'b0, 32'h0);
        look("R12", 32'h0000_0000, 1'b0, 32'h0);

        // Table: four sizes into slots 0..3, then lookups
        for (int n = 0; n < 12; n++) begin
            if (TBL[n].is_fill)
                do_fill(TBL[n].va, TBL[n].pa, TBL[n].sz);
            else
                look($sformatf("R%0d", TBL[n].req), TBL[n].va, TBL[n].exp_hit, TBL[n].exp_pa);
        end

        // R6: refill invisible before the edge, visible after it
        fill_en = 1'b1; fill_va = 32'h5555_5000; fill_pa = 32'h6666_6000; fill_size = 2'd0;
        look("R6", 32'h5555_5123, 1'b0, 32'h0);
        @(negedge clk);
        fill_en = 1'b0;
        look("R6", 32'h5555_5123, 1'b1, 32'h6666_6123);

        // R9 / R10: invalidate with a refill in the same cycle
        inv_all = 1'b1;
        fill_en = 1'b1; fill_va = 32'h7777_7000; fill_pa = 32'h1111_1000; fill_size = 2'd0;
        look("R9", 32'h1234_5ABC, 1'b0, 32'h0);
        @(negedge clk);
        inv_all = 1'b0; fill_en = 1'b0;
        look("R9", 32'h1234_5ABC, 1'b0, 32'h0);
        look("R9", 32'hC3AB_CDEF, 1'b0, 32'h0);
        look("R10", 32'h7777_7ABC, 1'b0, 32'h0);

        // R7: eight refills fill slots 0..7 in order
        for (int i = 0; i < 8; i++)
            do_fill(32'h1000_0000 + (i << 12), 32'h8000_0000 + (i << 12), 2'd0);
        for (int i = 0; i < 8; i++)
            look("R7", 32'h1000_00AB + (i << 12), 1'b1, 32'h8000_00AB + (i << 12));

        // R8: full cache, victims follow the pointer 0..6
        for (int k = 0; k < 7; k++) begin
            do_fill(32'h1100_0000 + (k << 12), 32'h9000_0000 + (k << 12), 2'd0);
            look("R8", 32'h1100_0010 + (k << 12), 1'b1, 32'h9000_0010 + (k << 12));
            look("R8", 32'h1000_0010 + (k << 12), 1'b0, 32'h0);
            look("R8", 32'h1000_0010 + ((k + 1) << 12), 1'b1, 32'h8000_0010 + ((k + 1) << 12));
        end

        // R11 / R7: pointer now 7; after invalidate, refills start at slot 0
        do_inv();
        do_fill(32'h4000_1000, 32'h6000_1000, 2'd0);   // slot 0, 4 KB
        do_fill(32'h4000_0000, 32'h7000_0000, 2'd3);   // slot 1, 16 MB
        look("R11", 32'h4000_1234, 1'b1, 32'h6000_1234);
        do_inv();
        do_fill(32'h4000_0000, 32'h7000_0000, 2'd3);   // slot 0, 16 MB
        do_fill(32'h4000_1000, 32'h6000_1000, 2'd0);   // slot 1, 4 KB
        look("R11", 32'h4000_1234, 1'b1, 32'h7000_1234);
        look("R5", 32'h40F0_0000, 1'b1, 32'h70F0_0000);

        // R8: fill slots 2..7, then wrap from slot 7 to slot 0
        for (int i = 0; i < 6; i++)
            do_fill(32'h2000_0000 + (i << 12), 32'hA000_0000 + (i << 12), 2'd0);
        do_fill(32'h3000_0000, 32'hB000_0000, 2'd0);   // evicts slot 7
        look("R8", 32'h2000_5000, 1'b0, 32'h0);
        look("R8", 32'h2000_4000, 1'b1, 32'hA000_4000);
        look("R8", 32'h3000_0444, 1'b1, 32'hB000_0444);
        do_fill(32'h3000_1000, 32'hB000_1000, 2'd0);   // evicts slot 0
        look("R8", 32'h4000_1234, 1'b1, 32'h6000_1234);
        look("R8", 32'h40F0_0000, 1'b0, 32'h0);

        // R1: reset in mid-run empties the cache
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look("R1", 32'h3000_0444, 1'b0, 32'h0);
        look("R1", 32'h2000_4000, 1'b0, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule